// File: doc/BRIEF.md
# Serial NOR Flash Emulator

This block behaves as a small serial NOR flash memory on the slave side of an SPI link in mode 0. The storage is held in on-chip registers, 2 KB by default. A host drives the chip-select, serial-clock and data-in pins and reads the data-out pin. The block decodes a write-enable, a status read, a data read, a page program and three erase sizes. Programming follows NOR rules: a data byte can only clear bits, and an erase returns a whole region to FFh.

Programs and erases are armed by a write-enable latch and take effect only when chip select rises on a byte boundary. Each accepted program or erase starts an emulated internal cycle. For the length of that cycle the write-in-progress status bit is high and the block ignores every command except the status read. The length of the cycle comes from the `busy_cycles` input, so a test environment can model short or long flash timing. The SPI pins are sampled with the system clock, which must run at least six times faster than the serial clock.

Top module: `spi_nor_emu`

## Requirements
- R1: A page program (opcode 02h) stores the old byte ANDed with the incoming byte. A bit that is 0 never returns to 1 through programming.
- R2: Erase sets every byte of an aligned region to FFh. Opcode 20h erases a 512-byte subsector, opcode D8h erases a 1 KB sector and opcode C7h erases the whole array. Bytes outside the region are unchanged.
- R3: A program or erase is accepted only when the write-enable latch was already set when its opcode arrived. Opcode 06h sets the latch, which is status bit 1, when chip select rises after it. A program or erase sent without the latch has no effect on the array or the status.
- R4: Program data bytes go to consecutive addresses inside one 256-byte page. After the last byte of the page, the next data byte goes to the first byte of the same page. The neighbouring page is not touched.
- R5: A program or erase takes effect only when chip select rises after a whole number of bytes. A page program also needs three address bytes and at least one data byte. A subsector or sector erase needs three address bytes. Any frame that does not meet these conditions is discarded and leaves the write-enable latch unchanged.
- R6: After an accepted program or erase, status bit 0 (write in progress) is high for exactly `busy_cycles`+1 clock cycles, starting the cycle after the commit. When it falls, the write-enable latch is cleared.
- R7: While write in progress is high, every opcode except 05h is ignored. This includes write-enable, read, program and erase.
- R8: Opcode 05h shifts out the status byte {6'b0, latch, busy}, MSB first. The byte repeats for as long as chip select stays low, and each repeat shows the current status.
- R9: Opcode 03h takes a 24-bit address, MSB first, of which the low 11 bits are used. It then returns bytes from consecutive addresses, MSB first, and wraps from the last byte of the array to byte 0. The data-out pin is low whenever the block is not sending.
- R10: After reset every array byte is FFh and the status byte is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the SPI pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_cycles | input | 16 | Length of the emulated program/erase cycle, minus one |
| sclk | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |

## Verification
A table of program, subsector-erase, sector-erase and read steps is applied to the same few addresses. Repeated programs of one byte with different patterns show whether the block ANDs, overwrites or ORs. Erases are followed by reads just inside and just outside the region, which exposes wrong region sizes or wrong alignment. Directed frames then cover the cases that should be discarded or ignored: a frame with no write-enable, a frame with no data, a frame ending mid-byte, a short address, and commands sent while busy. These are told apart from real commits by the array contents and by the status byte. A page-crossing program, a read that runs across the end of the array, and a repeated status read check the address arithmetic and the MSB-first bit order.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

  localparam logic [7:0] CMD_WREN      = 8'h06;
  localparam logic [7:0] CMD_RDSR      = 8'h05;
  localparam logic [7:0] CMD_READ      = 8'h03;
  localparam logic [7:0] CMD_PROG      = 8'h02;
  localparam logic [7:0] CMD_ERASE_SUB = 8'h20;
  localparam logic [7:0] CMD_ERASE_SEC = 8'hD8;
  localparam logic [7:0] CMD_ERASE_ALL = 8'hC7;

  typedef enum logic [3:0] {
    OP_IDLE, OP_SKIP, OP_WREN, OP_RDSR, OP_READ,
    OP_PROG, OP_ERASE_SUB, OP_ERASE_SEC, OP_ERASE_ALL
  } op_e;

  // NOR rule: a program can only clear bits
  function automatic logic [7:0] nor_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Address bits that must match for a region of 2**low_bits bytes
  function automatic logic [31:0] keep_mask(input int unsigned low_bits);
    return ~((32'd1 << low_bits) - 32'd1);
  endfunction

  function automatic logic [7:0] status_byte(input logic wel, input logic wip);
    return {6'b0, wel, wip};
  endfunction

endpackage

// File: rtl/spi_nor_frontend.sv
module spi_nor_frontend (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       frame_start,
  output logic       frame_end,
  output logic       aligned
);
  logic       sclk_s, sclk_d, cs_s, cs_d, mosi_s;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic       sel, rise, fall;

  assign sel         = ~cs_s;
  assign rise        = sel & sclk_s & ~sclk_d;
  assign fall        = sel & ~sclk_s & sclk_d;
  assign frame_start = cs_d & ~cs_s;
  assign frame_end   = ~cs_d & cs_s;
  assign aligned     = (bit_cnt == 3'd0);
  assign byte_done   = rise & (bit_cnt == 3'd7);
  assign rx_byte     = {shreg, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s  <= 1'b0;
      sclk_d  <= 1'b0;
      cs_s    <= 1'b1;
      cs_d    <= 1'b1;
      mosi_s  <= 1'b0;
      bit_cnt <= 3'd0;
      shreg   <= 7'd0;
      miso    <= 1'b0;
    end else begin
      sclk_s <= sclk;
      sclk_d <= sclk_s;
      cs_s   <= cs_n;
      cs_d   <= cs_s;
      mosi_s <= mosi;
      if (frame_start) begin
        bit_cnt <= 3'd0;
      end else if (rise) begin
        shreg   <= {shreg[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (!sel)       miso <= 1'b0;
      else if (fall)  miso <= tx_byte[~bit_cnt];
    end
  end
endmodule

// File: rtl/spi_nor_busy.sv
module spi_nor_busy #(
  parameter int BUSY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUSY_W-1:0] busy_cycles,
  output logic              wip,
  output logic              done
);
  logic [BUSY_W-1:0] cnt_q;

  assign done = wip && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip   <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      wip   <= 1'b1;
      cnt_q <= busy_cycles;
    end else if (wip) begin
      if (cnt_q == '0) wip   <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/spi_nor_array.sv
module spi_nor_array
  import spi_nor_pkg::*;
#(
  parameter int MEM_AW  = 11,
  parameter int PAGE_AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      buf_clear,
  input  logic                      buf_wr,
  input  logic [PAGE_AW-1:0]        buf_idx,
  input  logic [7:0]                buf_din,
  input  logic                      prog_en,
  input  logic [MEM_AW-PAGE_AW-1:0] prog_page,
  input  logic                      erase_en,
  input  logic [MEM_AW-1:0]         erase_addr,
  input  logic [MEM_AW-1:0]         erase_mask,
  input  logic [MEM_AW-1:0]         rd_addr,
  output logic [7:0]                rd_data
);
  localparam int MEM_BYTES  = 1 << MEM_AW;
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  logic [7:0] pbuf  [PAGE_BYTES];
  logic [7:0] cells [MEM_BYTES];

  // Page staging buffer: data bytes of one frame, merged NOR-style
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
    end else if (buf_clear) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
    end else if (buf_wr) begin
      pbuf[buf_idx] <= nor_merge(pbuf[buf_idx], buf_din);
    end
  end

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_cell
    localparam logic [MEM_AW-1:0] IDX = MEM_AW'(g);
    logic [7:0] cell_q;
    logic       hit_erase, hit_prog;
    assign hit_erase = erase_en && (((IDX ^ erase_addr) & erase_mask) == '0);
    assign hit_prog  = prog_en && (IDX[MEM_AW-1:PAGE_AW] == prog_page);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cell_q <= 8'hFF;
      else if (hit_erase) cell_q <= 8'hFF;
      else if (hit_prog)  cell_q <= nor_merge(cell_q, pbuf[IDX[PAGE_AW-1:0]]);
    end
    assign cells[g] = cell_q;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/spi_nor_emu.sv
module spi_nor_emu
  import spi_nor_pkg::*;
#(
  parameter int MEM_AW  = 11,
  parameter int PAGE_AW = 8,
  parameter int SUB_AW  = 9,
  parameter int SEC_AW  = 10,
  parameter int BUSY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUSY_W-1:0] busy_cycles,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso
);
  localparam int PAGE_NUM_W = MEM_AW - PAGE_AW;
  localparam logic [MEM_AW-1:0] SUB_MASK = MEM_AW'(keep_mask(SUB_AW));
  localparam logic [MEM_AW-1:0] SEC_MASK = MEM_AW'(keep_mask(SEC_AW));

  // frame events from the pin front end
  logic       byte_done, frame_start, frame_end, aligned;
  logic [7:0] rx_byte;

  // command state
  op_e               op_q, op_decoded;
  logic [2:0]        byte_cnt_q;
  logic [MEM_AW-1:0] addr_q, addr_next, rd_ptr_q, rd_addr;
  logic [PAGE_AW-1:0] pg_off_q;
  logic              got_data_q, wel_q;
  logic [7:0]        tx_q, rd_data, status;

  // named internal events (used by the bound checker)
  logic wip, busy_done, commit_ok, wren_commit, prog_commit, erase_commit, commit_any;
  logic buf_clear, buf_wr;
  logic [MEM_AW-1:0] erase_mask;

  spi_nor_frontend u_fe (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .tx_byte(tx_q), .miso(miso), .byte_done(byte_done), .rx_byte(rx_byte),
    .frame_start(frame_start), .frame_end(frame_end), .aligned(aligned)
  );

  spi_nor_busy #(.BUSY_W(BUSY_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(commit_any), .busy_cycles(busy_cycles),
    .wip(wip), .done(busy_done)
  );

  assign status    = status_byte(wel_q, wip);
  assign addr_next = MEM_AW'({addr_q, rx_byte});
  assign rd_addr   = (byte_cnt_q == 3'd3) ? addr_next : rd_ptr_q;

  always_comb begin
    op_decoded = OP_SKIP;
    case (rx_byte)
      CMD_RDSR:      op_decoded = OP_RDSR;
      CMD_WREN:      if (!wip)          op_decoded = OP_WREN;
      CMD_READ:      if (!wip)          op_decoded = OP_READ;
      CMD_PROG:      if (!wip && wel_q) op_decoded = OP_PROG;
      CMD_ERASE_SUB: if (!wip && wel_q) op_decoded = OP_ERASE_SUB;
      CMD_ERASE_SEC: if (!wip && wel_q) op_decoded = OP_ERASE_SEC;
      CMD_ERASE_ALL: if (!wip && wel_q) op_decoded = OP_ERASE_ALL;
      default: ;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_ERASE_SUB: erase_mask = SUB_MASK;
      OP_ERASE_SEC: erase_mask = SEC_MASK;
      default:      erase_mask = '0;
    endcase
  end

  assign commit_ok    = frame_end && aligned;
  assign wren_commit  = commit_ok && (op_q == OP_WREN);
  assign prog_commit  = commit_ok && (op_q == OP_PROG) && (byte_cnt_q == 3'd4) && got_data_q;
  assign erase_commit = commit_ok && ((op_q == OP_ERASE_ALL) ||
                        (((op_q == OP_ERASE_SUB) || (op_q == OP_ERASE_SEC)) && (byte_cnt_q == 3'd4)));
  assign commit_any   = prog_commit || erase_commit;
  assign buf_clear    = byte_done && (byte_cnt_q == 3'd0) && (op_decoded == OP_PROG);
  assign buf_wr       = byte_done && (byte_cnt_q == 3'd4) && (op_q == OP_PROG);

  spi_nor_array #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .buf_clear(buf_clear), .buf_wr(buf_wr), .buf_idx(pg_off_q), .buf_din(rx_byte),
    .prog_en(prog_commit), .prog_page(addr_q[MEM_AW-1:PAGE_AW]),
    .erase_en(erase_commit), .erase_addr(addr_q), .erase_mask(erase_mask),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_IDLE;
      byte_cnt_q <= 3'd0;
      addr_q     <= '0;
      rd_ptr_q   <= '0;
      pg_off_q   <= '0;
      got_data_q <= 1'b0;
      tx_q       <= 8'h00;
      wel_q      <= 1'b0;
    end else begin
      if (frame_start) begin
        op_q       <= OP_IDLE;
        byte_cnt_q <= 3'd0;
        got_data_q <= 1'b0;
        tx_q       <= 8'h00;
      end else if (frame_end) begin
        op_q <= OP_IDLE;
      end else if (byte_done) begin
        if (byte_cnt_q != 3'd4) byte_cnt_q <= byte_cnt_q + 3'd1;
        if (byte_cnt_q == 3'd0) begin
          op_q <= op_decoded;
          if (op_decoded == OP_RDSR) tx_q <= status;
        end else begin
          if (byte_cnt_q != 3'd4) addr_q <= addr_next;
          case (op_q)
            OP_RDSR: tx_q <= status;
            OP_READ: if (byte_cnt_q >= 3'd3) begin
              tx_q     <= rd_data;
              rd_ptr_q <= rd_addr + 1'b1;
            end
            OP_PROG: if (byte_cnt_q == 3'd3) begin
              pg_off_q <= addr_next[PAGE_AW-1:0];
            end else if (byte_cnt_q == 3'd4) begin
              pg_off_q   <= pg_off_q + 1'b1;
              got_data_q <= 1'b1;
            end
            default: ;
          endcase
        end
      end
      if (wren_commit)    wel_q <= 1'b1;
      else if (busy_done) wel_q <= 1'b0;
    end
  end

  initial begin
    if (PAGE_NUM_W < 1 || SUB_AW < PAGE_AW || SEC_AW < SUB_AW || SEC_AW > MEM_AW || MEM_AW > 24)
      $error("spi_nor_emu: inconsistent size parameters");
  end
endmodule

// File: rtl/spi_nor_emu_chk.sv
module spi_nor_emu_chk #(
  parameter int BUSY_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUSY_W-1:0] busy_cycles,
  input logic              wip,
  input logic              wel,
  input logic              commit_any,
  input logic              wren_commit,
  input logic              busy_done
);
  logic [BUSY_W:0] len_q, exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      exp_q <= '0;
    end else if (commit_any) begin
      len_q <= '0;
      exp_q <= {1'b0, busy_cycles} + 1'b1;
    end else if (wip) begin
      len_q <= len_q + 1'b1;
    end
  end

  assert_busy_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_any |=> wip);
  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (len_q == exp_q));
  assert_wel_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_done |=> (!wip && !wel));
  assert_commit_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_any |-> wel);
  assert_wel_from_wren_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(wren_commit));
  assert_quiet_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> (!commit_any && !wren_commit));
endmodule

bind spi_nor_emu spi_nor_emu_chk #(.BUSY_W(BUSY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_cycles(busy_cycles), .wip(wip), .wel(wel_q),
  .commit_any(commit_any), .wren_commit(wren_commit), .busy_done(busy_done)
);

// File: tb/spi_nor_emu_tb.sv
`timescale 1ns/1ps
module spi_nor_emu_tb;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] busy_cycles = 16'd20;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso;

  int n_checks = 0, n_fail = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  spi_nor_emu u_dut (.clk(clk), .rst_n(rst_n), .busy_cycles(busy_cycles),
                     .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  typedef struct packed {
    logic [1:0]  kind;   // 0 program, 1 subsector erase, 2 sector erase, 3 read only
    logic [15:0] addr;
    logic [7:0]  data;
    logic [15:0] raddr;
    logic [7:0]  expv;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd0, 16'h0010, 8'hA5, 16'h0010, 8'hA5},
    '{2'd0, 16'h0010, 8'h3C, 16'h0010, 8'h24},
    '{2'd0, 16'h0010, 8'hFF, 16'h0010, 8'h24},
    '{2'd0, 16'h02FF, 8'h0F, 16'h02FF, 8'h0F},
    '{2'd1, 16'h0005, 8'h00, 16'h0010, 8'hFF},
    '{2'd3, 16'h0000, 8'h00, 16'h02FF, 8'h0F},
    '{2'd0, 16'h0400, 8'h81, 16'h0400, 8'h81},
    '{2'd2, 16'h07AB, 8'h00, 16'h0400, 8'hFF},
    '{2'd3, 16'h0000, 8'h00, 16'h02FF, 8'h0F}
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int b = 7; b > 7 - nbits; b--) begin
      mosi = tx[b];
      repeat (H) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic send_addr(input logic [15:0] a);
    logic [7:0] d;
    xb(8'h00, d); xb(a[15:8], d); xb(a[7:0], d);
  endtask

  task automatic wren();
    logic [7:0] d;
    cs_lo(); xb(8'h06, d); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_lo(); xb(8'h05, d); xb(8'h00, s); cs_hi();
  endtask

  task automatic read1(input logic [15:0] a, output logic [7:0] v);
    logic [7:0] d;
    cs_lo(); xb(8'h03, d); send_addr(a); xb(8'h00, v); cs_hi();
  endtask

  task automatic prog1(input logic [15:0] a, input logic [7:0] v);
    logic [7:0] d;
    cs_lo(); xb(8'h02, d); send_addr(a); xb(v, d); cs_hi();
  endtask

  task automatic erase(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] d;
    cs_lo(); xb(op, d); send_addr(a); cs_hi();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 100; k++) begin
      rdsr(s);
      if (!s[0]) return;
    end
    chk("R6", "busy never ended", 8'h01, 8'h00);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, s, d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10: reset state
    rdsr(s);          chk("R10", "status after reset", s, 8'h00);
    read1(16'h0000, v); chk("R10", "byte 000 after reset", v, 8'hFF);
    read1(16'h07FF, v); chk("R10", "byte 7FF after reset", v, 8'hFF);

    // vector table: program / erase / read
    foreach (VECS[i]) begin
      case (VECS[i].kind)
        2'd0: begin wren(); prog1(VECS[i].addr, VECS[i].data); end
        2'd1: begin wren(); erase(8'h20, VECS[i].addr); end
        2'd2: begin wren(); erase(8'hD8, VECS[i].addr); end
        default: ;
      endcase
      wait_idle();
      read1(VECS[i].raddr, v);
      chk((VECS[i].kind == 2'd0) ? "R1" : "R2", $sformatf("vector %0d", i), v, VECS[i].expv);
    end

    // R9: read streams across the end of the array
    wren(); prog1(16'h07FF, 8'h5A); wait_idle();
    wren(); prog1(16'h0000, 8'hC3); wait_idle();
    cs_lo(); xb(8'h03, d); send_addr(16'h07FE);
    xb(8'h00, v); chk("R9", "stream 7FE", v, 8'hFF);
    xb(8'h00, v); chk("R9", "stream 7FF", v, 8'h5A);
    xb(8'h00, v); chk("R9", "stream wrap 000", v, 8'hC3);
    cs_hi();

    // R3: program and erase without write enable
    prog1(16'h0100, 8'h00);
    rdsr(s);            chk("R3", "status after unarmed program", s, 8'h00);
    read1(16'h0100, v); chk("R3", "unarmed program", v, 8'hFF);
    erase(8'h20, 16'h0200);
    read1(16'h02FF, v); chk("R3", "unarmed erase", v, 8'h0F);

    // R3/R8: write enable sets status bit 1
    wren();
    rdsr(s); chk("R3", "status after write enable", s, 8'h02);

    // R5: discarded frames
    cs_lo(); xb(8'h02, d); send_addr(16'h0120); cs_hi();
    rdsr(s);            chk("R5", "status after program without data", s, 8'h02);
    cs_lo(); xb(8'h02, d); send_addr(16'h0130); xb(8'h00, d); xbits(8'h00, 3, d); cs_hi();
    read1(16'h0130, v); chk("R5", "mid-byte abort", v, 8'hFF);
    cs_lo(); xb(8'h20, d); xb(8'h00, d); xb(8'h02, d); cs_hi();
    rdsr(s);            chk("R5", "status after short erase", s, 8'h02);
    read1(16'h02FF, v); chk("R5", "short erase", v, 8'h0F);

    // R4: program wraps inside its page
    cs_lo(); xb(8'h02, d); send_addr(16'h01FE);
    xb(8'h11, d); xb(8'h22, d); xb(8'h33, d); xb(8'h44, d);
    cs_hi();
    wait_idle();
    rdsr(s);            chk("R6", "latch cleared after cycle", s, 8'h00);
    read1(16'h01FE, v); chk("R4", "byte 1FE", v, 8'h11);
    read1(16'h01FF, v); chk("R4", "byte 1FF", v, 8'h22);
    read1(16'h0100, v); chk("R4", "wrapped byte 100", v, 8'h33);
    read1(16'h0101, v); chk("R4", "wrapped byte 101", v, 8'h44);
    read1(16'h0200, v); chk("R4", "next page untouched", v, 8'hFF);

    // R6/R7/R8: long busy cycle
    busy_cycles = 16'd4000;
    wren(); prog1(16'h0140, 8'h00);
    cs_lo(); xb(8'h05, d);
    xb(8'h00, s); chk("R8", "status repeat 1", s, 8'h03);
    xb(8'h00, s); chk("R8", "status repeat 2", s, 8'h03);
    xb(8'h00, s); chk("R6", "status repeat 3 busy", s, 8'h03);
    cs_hi();
    wren(); prog1(16'h0150, 8'h00);
    read1(16'h0140, v); chk("R7", "read while busy returns nothing", v, 8'h00);
    wait_idle();
    rdsr(s);            chk("R7", "status after busy", s, 8'h00);
    read1(16'h0150, v); chk("R7", "program while busy", v, 8'hFF);
    read1(16'h0140, v); chk("R1", "long cycle program", v, 8'h00);

    // R2: whole-array erase
    busy_cycles = 16'd20;
    wren(); cs_lo(); xb(8'hC7, d); cs_hi();
    wait_idle();
    read1(16'h0140, v); chk("R2", "bulk erase 140", v, 8'hFF);
    read1(16'h02FF, v); chk("R2", "bulk erase 2FF", v, 8'hFF);
    read1(16'h07FF, v); chk("R2", "bulk erase 7FF", v, 8'hFF);

    finish_run();
  end
endmodule